// File: doc/BRIEF.md
# Shadowed Real-Time Clock

This block is a real-time clock peripheral on a plain memory-mapped write/read bus. Software sees a control word, a read-only status word, a seconds count, an alarm value, a watchdog count and six persistent configuration words. Each register page answers at three addresses: a plain write, an OR-in alias that sets bits and an AND-NOT alias that clears bits. Software can therefore change single bits without a read-modify-write.

Writes to the seconds, alarm and persistent words do not act at once. They land in a fast shadow copy and raise a per-register pending bit. A copy engine then moves one pending word per slow-domain tick into the always-on copy, lowest pending index first. Reads of these words return the always-on copy, so software polls the pending bitmap in the status word to learn when a write has taken effect. The always-on side counts seconds from a crystal prescaler, compares the count with the alarm value and raises the alarm flag. A millisecond prescaler drives a watchdog down-counter. The slow clock is modelled as a one-cycle enable, `slow_tick`, on the single bus clock.

Top module: `rtc_shadow_core`

## Requirements
- R1: After a synchronous active-low reset, the control word, watchdog count, seconds count, all shadow and always-on words and the pending bitmap are zero, and `alarm_irq` and `wdog_rst` are low.
- R2: `bus_addr[7:4]` selects the register page and `bus_addr[3:2]` the access kind. 00 writes the data, 01 ORs it into the register, 10 clears the bits that are 1 in the data, and 11 is ignored. A write is taken on the clock edge where `bus_wr` is high. `bus_rdata` is combinational from `bus_addr` and ignores the access bits.
- R3: The pages are: control 0, status 1, seconds 3, alarm 4, watchdog 5, and persistent words 0 to 5 at pages 6 to 11. Writing a shadowed word sets its pending bit in status bits 23:16 on the next edge, with persistent0..5 at bitmap bits 0..5, alarm at bit 6 and seconds at bit 7. Reads of a shadowed word return its always-on copy, which is unchanged until that copy happens.
- R4: On each edge with `slow_tick` high and at least one pending bit, exactly the lowest-index pending word is copied and its pending bit cleared. Without `slow_tick` no pending bit clears. A write in the same edge keeps the bit pending.
- R5: A write to persistent1 that leaves its bit 31 at 1 marks all eight shadowed words pending.
- R6: The status word is read-only. Bit 31 reads 1, bit 28 reflects `xtal_32000_ok`, bit 27 reflects `xtal_32768_ok`, and writes to page 1 change nothing.
- R7: Control bits 0 (alarm interrupt enable), 1 (millisecond interrupt enable) and 4 (watchdog enable) follow all three access kinds. Bit 2 (alarm flag) is set only by the hardware and cleared only through the clear alias with data bit 2 at 1. Other bits read 0.
- R8: The seconds count increments once every `XTAL_A_DIV` slow ticks when the always-on persistent0 bit 6 is 1, otherwise once every `XTAL_B_DIV` slow ticks. The copy of the seconds word replaces the count, taking precedence over an increment in the same edge.
- R9: The alarm flag is set one edge after the seconds count becomes equal to the always-on alarm value while always-on persistent0 bit 2 is 1. `alarm_irq` equals the flag ANDed with control bit 0.
- R10: A millisecond tick occurs every `MS_DIV` slow ticks. While control bit 4 is 1 and the watchdog count is nonzero, each millisecond tick decrements the count. The step from 1 to 0 makes `wdog_rst` high for exactly one cycle. With bit 4 at 0 the count holds, and a bus write to page 5 loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every register is clocked by it |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable that marks a slow-domain clock edge |
| xtal_32000_ok | input | 1 | Strap: a 32000 Hz crystal is fitted |
| xtal_32768_ok | input | 1 | Strap: a 32768 Hz crystal is fitted |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address: page in bits 7:4, access kind in bits 3:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| alarm_irq | output | 1 | Alarm interrupt request |
| wdog_rst | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Bus-side results are due one edge after the write: the control word, the watchdog count and the pending bits are read back at the falling edge that follows the write strobe. Copies are due on the edge of each slow tick, so the bench raises `slow_tick` for an exact count of edges and then reads. Prescaled results depend only on how many ticks were given, because the prescalers run continuously. The bench therefore checks counts over windows that are whole multiples of a divisor: N seconds in N·divisor ticks, and exactly two millisecond ticks in eight. The alarm flag lags the seconds match by one edge, so it is checked only after windows long enough to pass the match.

// File: rtl/rtc_shadow_pkg.sv
// Package: shared constants, access kinds and address helpers for the
// shadowed real-time clock. Assumes an 8-bit byte address split into a
// 4-bit page and a 2-bit access kind.
package rtc_shadow_pkg;

    localparam int DW    = 32;
    localparam int AW    = 8;
    localparam int NSLOT = 8;

    // pending-bitmap positions that the copy order depends on
    localparam int SLOT_ALARM = 6;
    localparam int SLOT_SEC   = 7;

    localparam logic [3:0] PAGE_CTRL  = 4'h0;
    localparam logic [3:0] PAGE_STAT  = 4'h1;
    localparam logic [3:0] PAGE_SEC   = 4'h3;
    localparam logic [3:0] PAGE_ALARM = 4'h4;
    localparam logic [3:0] PAGE_WDOG  = 4'h5;
    localparam logic [3:0] PAGE_P0    = 4'h6;
    localparam logic [3:0] PAGE_P5    = 4'hB;

    localparam int CTL_ALARM_IE = 0;
    localparam int CTL_MS_IE    = 1;
    localparam int CTL_FLAG     = 2;
    localparam int CTL_WDOG_EN  = 4;

    localparam int P0_ALARM_EN  = 2;
    localparam int P0_XTAL_SEL  = 6;
    localparam int P1_FORCE     = 31;

    localparam int STAT_PRESENT = 31;
    localparam int STAT_X32000  = 28;
    localparam int STAT_X32768  = 27;
    localparam int STAT_PEND_LSB = 16;

    typedef enum logic [1:0] {
        ACC_WRITE = 2'b00,
        ACC_SET   = 2'b01,
        ACC_CLEAR = 2'b10,
        ACC_NONE  = 2'b11
    } acc_e;

    // Result of applying one access kind to an old register value.
    function automatic logic [DW-1:0] apply_acc(acc_e kind, logic [DW-1:0] old_v,
                                                logic [DW-1:0] data);
        case (kind)
            ACC_WRITE: return data;
            ACC_SET:   return old_v | data;
            ACC_CLEAR: return old_v & ~data;
            default:   return old_v;
        endcase
    endfunction

    // True when a page holds a shadowed word.
    function automatic logic page_is_slot(logic [3:0] page);
        return (page == PAGE_SEC) || (page == PAGE_ALARM) ||
               ((page >= PAGE_P0) && (page <= PAGE_P5));
    endfunction

    // Pending-bitmap index of a shadowed page.
    function automatic logic [2:0] slot_of(logic [3:0] page);
        logic [3:0] rel;
        rel = page - PAGE_P0;
        if (page == PAGE_SEC)   return 3'(SLOT_SEC);
        if (page == PAGE_ALARM) return 3'(SLOT_ALARM);
        return rel[2:0];
    endfunction

endpackage

// File: rtl/rtc_bus_regs.sv
// Module: bus-side register file. Decodes the page and access kind, holds
// the control word and the eight shadow words, and reports which shadow
// words were written this cycle. Assumes writes are single-cycle strobes
// and that the alarm flag set request comes from the always-on side.
module rtc_bus_regs
    import rtc_shadow_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [AW-1:0]              addr,
    input  logic [DW-1:0]              wdata,
    input  logic                       flag_set,
    input  logic [DW-1:0]              wdog_cnt,
    output logic [DW-1:0]              ctrl_q,
    output logic                       wdog_load,
    output logic [DW-1:0]              wdog_val,
    output logic [NSLOT-1:0][DW-1:0]   shadow_q,
    output logic [NSLOT-1:0]           mark
);

    localparam logic [DW-1:0] CTL_RW_MASK =
        (DW'(1) << CTL_ALARM_IE) | (DW'(1) << CTL_MS_IE) | (DW'(1) << CTL_WDOG_EN);

    logic [3:0]       page;
    acc_e             kind;
    logic             hit;
    logic [NSLOT-1:0] slot_we;
    logic [DW-1:0]    ctrl_d;
    logic [DW-1:0]    p1_new;
    logic             force_all;

    // Split the address into page and access kind.
    always_comb begin
        page = addr[7:4];
        kind = acc_e'(addr[3:2]);
        hit  = wr_en && (kind != ACC_NONE);
    end

    // Per-slot write enables from the page decode.
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            slot_we[s] = hit && page_is_slot(page) && (slot_of(page) == 3'(s));
        end
    end

    // Next control word: software bits by access kind, flag by hardware or clear alias.
    always_comb begin
        ctrl_d = ctrl_q;
        if (hit && page == PAGE_CTRL) begin
            ctrl_d = (apply_acc(kind, ctrl_q, wdata) & CTL_RW_MASK) |
                     (ctrl_q & (DW'(1) << CTL_FLAG));
            if (kind == ACC_CLEAR && wdata[CTL_FLAG]) ctrl_d[CTL_FLAG] = 1'b0;
        end
        if (flag_set) ctrl_d[CTL_FLAG] = 1'b1;
    end

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // Shadow words, one register per slot.
    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_shadow
            always_ff @(posedge clk) begin
                if (!rst_n)          shadow_q[g] <= '0;
                else if (slot_we[g]) shadow_q[g] <= apply_acc(kind, shadow_q[g], wdata);
            end
        end
    endgenerate

    // Pending marks, widened to every slot by the forced-update bit.
    always_comb begin
        p1_new    = apply_acc(kind, shadow_q[1], wdata);
        force_all = slot_we[1] && p1_new[P1_FORCE];
        mark      = force_all ? {NSLOT{1'b1}} : slot_we;
    end

    // Watchdog count load request.
    always_comb begin
        wdog_load = hit && (page == PAGE_WDOG);
        wdog_val  = apply_acc(kind, wdog_cnt, wdata);
    end

    // R7: the flag falls only through a clear-alias write carrying bit 2
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_q[CTL_FLAG]) |->
            $past(wr_en && addr[7:4] == PAGE_CTRL && addr[3:2] == 2'b10 && wdata[CTL_FLAG]));

endmodule

// File: rtl/rtc_copy_engine.sv
// Module: pending bitmap and always-on copies. On each slow tick it copies
// the lowest-index pending shadow word into its always-on register and
// clears that pending bit. Assumes marks arrive as one-cycle pulses.
module rtc_copy_engine
    import rtc_shadow_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       slow_tick,
    input  logic [NSLOT-1:0]           mark,
    input  logic [NSLOT-1:0][DW-1:0]   shadow_q,
    output logic [NSLOT-1:0]           stale_q,
    output logic [NSLOT-2:0][DW-1:0]   aon_q,
    output logic                       sec_load,
    output logic [DW-1:0]              sec_val
);

    logic [NSLOT-1:0] grant;
    logic             copy_en;

    // Lowest-index pending slot wins.
    always_comb begin
        grant = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (stale_q[i]) grant = NSLOT'(1) << i;
        end
        copy_en = slow_tick && (|stale_q);
    end

    // Pending bitmap: a new mark overrides a copy in the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) stale_q <= '0;
        else        stale_q <= (stale_q & ~(copy_en ? grant : '0)) | mark;
    end

    // Always-on copies of every slot except seconds.
    generate
        for (genvar g = 0; g < NSLOT - 1; g++) begin : g_aon
            always_ff @(posedge clk) begin
                if (!rst_n)                   aon_q[g] <= '0;
                else if (copy_en && grant[g]) aon_q[g] <= shadow_q[g];
            end
        end
    endgenerate

    // Seconds slot is loaded into the live counter instead.
    always_comb begin
        sec_load = copy_en && grant[SLOT_SEC];
        sec_val  = shadow_q[SLOT_SEC];
    end

    // R4: at most one pending bit retires per edge
    assert_single_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(stale_q) & ~stale_q) <= 1);

    // R4: a pending bit retires only on a slow tick
    assert_copy_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(stale_q) & ~stale_q)) |-> $past(slow_tick));

endmodule

// File: rtl/rtc_time_base.sv
// Module: always-on timekeeping. Seconds prescaler and counter, alarm
// compare edge detect, millisecond prescaler and watchdog down-counter.
// Assumes slow_tick is a one-cycle enable and divisors are at least 2.
module rtc_time_base
    import rtc_shadow_pkg::*;
#(
    parameter int XTAL_A_DIV = 32000,
    parameter int XTAL_B_DIV = 32768,
    parameter int MS_DIV     = 32
)(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           slow_tick,
    input  logic           xtal_sel,
    input  logic           alarm_en,
    input  logic [DW-1:0]  alarm_val,
    input  logic           sec_load,
    input  logic [DW-1:0]  sec_val,
    input  logic           wdog_en,
    input  logic           wdog_load,
    input  logic [DW-1:0]  wdog_val,
    output logic [DW-1:0]  seconds_q,
    output logic           alarm_hit,
    output logic [DW-1:0]  wdog_cnt,
    output logic           wdog_rst
);

    localparam int DIV_MAX = (XTAL_A_DIV > XTAL_B_DIV) ? XTAL_A_DIV : XTAL_B_DIV;
    localparam int PW      = $clog2(DIV_MAX) + 1;
    localparam int MW      = $clog2(MS_DIV) + 1;
    localparam logic [PW-1:0] LIM_A  = PW'(XTAL_A_DIV - 1);
    localparam logic [PW-1:0] LIM_B  = PW'(XTAL_B_DIV - 1);
    localparam logic [MW-1:0] LIM_MS = MW'(MS_DIV - 1);

    logic [PW-1:0] pre_q;
    logic [PW-1:0] pre_lim;
    logic          sec_tick;
    logic [MW-1:0] ms_q;
    logic          ms_tick;
    logic          match_now;
    logic          match_q;
    logic          wdog_step;

    // Tick decode for both prescalers.
    always_comb begin
        pre_lim  = xtal_sel ? LIM_A : LIM_B;
        sec_tick = slow_tick && (pre_q >= pre_lim);
        ms_tick  = slow_tick && (ms_q == LIM_MS);
    end

    // Seconds prescaler; the >= wrap absorbs a divisor change.
    always_ff @(posedge clk) begin
        if (!rst_n)         pre_q <= '0;
        else if (slow_tick) pre_q <= sec_tick ? '0 : pre_q + 1'b1;
    end

    // Seconds counter; a copy replaces the count.
    always_ff @(posedge clk) begin
        if (!rst_n)        seconds_q <= '0;
        else if (sec_load) seconds_q <= sec_val;
        else if (sec_tick) seconds_q <= seconds_q + 1'b1;
    end

    // Alarm compare with edge detect.
    always_comb begin
        match_now = alarm_en && (seconds_q == alarm_val);
        alarm_hit = match_now && !match_q;
    end

    // Previous compare state.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_now;
    end

    // Millisecond prescaler.
    always_ff @(posedge clk) begin
        if (!rst_n)         ms_q <= '0;
        else if (slow_tick) ms_q <= ms_tick ? '0 : ms_q + 1'b1;
    end

    assign wdog_step = ms_tick && wdog_en && (wdog_cnt != '0);

    // Watchdog count and expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdog_cnt <= '0;
            wdog_rst <= 1'b0;
        end else begin
            wdog_rst <= !wdog_load && wdog_step && (wdog_cnt == DW'(1));
            if (wdog_load)      wdog_cnt <= wdog_val;
            else if (wdog_step) wdog_cnt <= wdog_cnt - 1'b1;
        end
    end

    // R10: the expiry pulse lasts a single cycle
    assert_wdog_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_rst |=> !wdog_rst);

    // R8: without a copy the count only ever steps by one
    assert_sec_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((seconds_q != $past(seconds_q)) && !$past(sec_load)) |->
            (seconds_q == $past(seconds_q) + 1'b1));

endmodule

// File: rtl/rtc_shadow_core.sv
// Module: top of the shadowed real-time clock. Joins the bus register file,
// the copy engine and the time base, and builds the read mux and the
// interrupt. Assumes a single clock with the slow domain as an enable.
module rtc_shadow_core
    import rtc_shadow_pkg::*;
#(
    parameter int XTAL_A_DIV = 32000,
    parameter int XTAL_B_DIV = 32768,
    parameter int MS_DIV     = 32
)(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slow_tick,
    input  logic          xtal_32000_ok,
    input  logic          xtal_32768_ok,
    input  logic          bus_wr,
    input  logic [7:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          alarm_irq,
    output logic          wdog_rst
);

    logic [DW-1:0]             ctrl_q;
    logic                      wdog_load;
    logic [DW-1:0]             wdog_val;
    logic [DW-1:0]             wdog_cnt;
    logic [NSLOT-1:0][DW-1:0]  shadow_q;
    logic [NSLOT-1:0]          mark;
    logic [NSLOT-1:0]          stale_q;
    logic [NSLOT-2:0][DW-1:0]  aon_q;
    logic                      sec_load;
    logic [DW-1:0]             sec_val;
    logic [DW-1:0]             seconds_q;
    logic                      alarm_hit;
    logic [3:0]                rd_page;
    logic [DW-1:0]             stat_word;

    rtc_bus_regs u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .flag_set  (alarm_hit),
        .wdog_cnt  (wdog_cnt),
        .ctrl_q    (ctrl_q),
        .wdog_load (wdog_load),
        .wdog_val  (wdog_val),
        .shadow_q  (shadow_q),
        .mark      (mark)
    );

    rtc_copy_engine u_copy (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .mark      (mark),
        .shadow_q  (shadow_q),
        .stale_q   (stale_q),
        .aon_q     (aon_q),
        .sec_load  (sec_load),
        .sec_val   (sec_val)
    );

    rtc_time_base #(
        .XTAL_A_DIV (XTAL_A_DIV),
        .XTAL_B_DIV (XTAL_B_DIV),
        .MS_DIV     (MS_DIV)
    ) u_time (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .xtal_sel  (aon_q[0][P0_XTAL_SEL]),
        .alarm_en  (aon_q[0][P0_ALARM_EN]),
        .alarm_val (aon_q[SLOT_ALARM]),
        .sec_load  (sec_load),
        .sec_val   (sec_val),
        .wdog_en   (ctrl_q[CTL_WDOG_EN]),
        .wdog_load (wdog_load),
        .wdog_val  (wdog_val),
        .seconds_q (seconds_q),
        .alarm_hit (alarm_hit),
        .wdog_cnt  (wdog_cnt),
        .wdog_rst  (wdog_rst)
    );

    // Status word assembly.
    always_comb begin
        stat_word = '0;
        stat_word[STAT_PRESENT] = 1'b1;
        stat_word[STAT_X32000]  = xtal_32000_ok;
        stat_word[STAT_X32768]  = xtal_32768_ok;
        stat_word[STAT_PEND_LSB +: NSLOT] = stale_q;
    end

    // Read mux by page.
    always_comb begin
        rd_page = bus_addr[7:4];
        case (rd_page)
            PAGE_CTRL:  bus_rdata = ctrl_q;
            PAGE_STAT:  bus_rdata = stat_word;
            PAGE_SEC:   bus_rdata = seconds_q;
            PAGE_ALARM: bus_rdata = aon_q[SLOT_ALARM];
            PAGE_WDOG:  bus_rdata = wdog_cnt;
            default: begin
                if (rd_page >= PAGE_P0 && rd_page <= PAGE_P5)
                    bus_rdata = aon_q[slot_of(rd_page)];
                else
                    bus_rdata = '0;
            end
        endcase
    end

    // Interrupt request.
    assign alarm_irq = ctrl_q[CTL_FLAG] & ctrl_q[CTL_ALARM_IE];

    // R9: a newly raised flag always follows a compare hit
    assert_flag_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_q[CTL_FLAG]) |-> $past(alarm_hit));

endmodule

// File: tb/rtc_shadow_core_test.sv
module rtc_shadow_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        alarm_irq;
    logic        wdog_rst;

    int checks = 0;
    int failures = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    rtc_shadow_core #(.XTAL_A_DIV(8), .XTAL_B_DIV(16), .MS_DIV(4)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .slow_tick     (slow_tick),
        .xtal_32000_ok (1'b1),
        .xtal_32768_ok (1'b0),
        .bus_wr        (bus_wr),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .alarm_irq     (alarm_irq),
        .wdog_rst      (wdog_rst)
    );

    // count watchdog pulses, one negedge per pulse cycle
    always @(negedge clk) if (rst_n && wdog_rst) pulses++;

    // {op(1=read-check,0=write), addr, data, expected}
    localparam int NV = 23;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h10, 32'h0,          32'h9000_0000}, // R1 R6 status at reset
        {1'b1, 8'h00, 32'h0,          32'h0000_0000}, // R1 control at reset
        {1'b0, 8'h00, 32'hFFFF_FFFF,  32'h0},         // R7 plain write all ones
        {1'b1, 8'h00, 32'h0,          32'h0000_0013}, // R7 flag not writable
        {1'b0, 8'h08, 32'h0000_0001,  32'h0},         // R2 clear alias
        {1'b1, 8'h00, 32'h0,          32'h0000_0012}, // R2
        {1'b0, 8'h04, 32'h0000_0001,  32'h0},         // R2 set alias
        {1'b1, 8'h00, 32'h0,          32'h0000_0013}, // R2
        {1'b0, 8'h0C, 32'h0,          32'h0},         // R2 access kind 11 ignored
        {1'b1, 8'h00, 32'h0,          32'h0000_0013}, // R2
        {1'b0, 8'h00, 32'h0,          32'h0},         // R7
        {1'b1, 8'h00, 32'h0,          32'h0000_0000}, // R7
        {1'b0, 8'h80, 32'h0000_AAAA,  32'h0},         // R3 persistent2
        {1'b1, 8'h10, 32'h0,          32'h9004_0000}, // R3 pending bit 2
        {1'b1, 8'h80, 32'h0,          32'h0000_0000}, // R3 always-on copy unchanged
        {1'b0, 8'h84, 32'h0000_5555,  32'h0},         // R2 set alias on shadow
        {1'b1, 8'h80, 32'h0,          32'h0000_0000}, // R3
        {1'b0, 8'h10, 32'hFFFF_FFFF,  32'h0},         // R6 write to status
        {1'b1, 8'h10, 32'h0,          32'h9004_0000}, // R6 unchanged
        {1'b0, 8'h30, 32'h0000_0064,  32'h0},         // R3 seconds
        {1'b0, 8'h40, 32'h0000_1234,  32'h0},         // R3 alarm
        {1'b0, 8'h90, 32'h0000_0077,  32'h0},         // R3 persistent3
        {1'b1, 8'h10, 32'h0,          32'h90CC_0000}  // R3 bits 7,6,3,2 pending
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic read_check(string tag, logic [7:0] a, logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        check(tag, d, exp);
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        slow_tick = 1'b1;
        repeat (n) @(negedge clk);
        slow_tick = 1'b0;
    endtask

    initial begin
        logic [31:0] s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq at reset", {31'b0, alarm_irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) read_check($sformatf("vector %0d", i), VEC[i][71:64], VEC[i][31:0]);
            else            bus_write(VEC[i][71:64], VEC[i][63:32]);
        end

        // R4 copy order: lowest pending first, one per tick
        ticks(1);
        read_check("R4 after p2 copy status", 8'h10, 32'h90C8_0000);
        read_check("R4 p2 value", 8'h80, 32'h0000_FFFF);
        ticks(1);
        read_check("R4 after p3 copy status", 8'h10, 32'h90C0_0000);
        read_check("R4 p3 value", 8'h90, 32'h0000_0077);
        ticks(1);
        read_check("R4 after alarm copy status", 8'h10, 32'h9080_0000);
        read_check("R4 alarm value", 8'h40, 32'h0000_1234);
        ticks(1);
        read_check("R4 all copied", 8'h10, 32'h9000_0000);
        read_check("R8 seconds replaced by copy", 8'h30, 32'h0000_0064);

        // R2 clear alias on a shadowed word
        bus_write(8'h88, 32'h0000_00F0);
        ticks(1);
        read_check("R2 clear alias on p2", 8'h80, 32'h0000_FF0F);

        // R5 forced update marks every slot
        bus_write(8'h70, 32'h8000_0000);
        read_check("R5 all pending", 8'h10, 32'h90FF_0000);
        ticks(8);
        read_check("R4 forced copies drained", 8'h10, 32'h9000_0000);
        read_check("R8 seconds recopied", 8'h30, 32'h0000_0064);

        // R8 slow divisor (bit 6 clear): 16 ticks per second
        ticks(48);
        read_check("R8 three seconds at divide 16", 8'h30, 32'h0000_0067);

        // R8 fast divisor (bit 6 set): 8 ticks per second
        bus_write(8'h60, 32'h0000_0040);
        ticks(1);
        ticks(20);
        bus_read(8'h30, s);
        ticks(40);
        read_check("R8 five seconds at divide 8", 8'h30, s + 32'd5);

        // R9 alarm
        bus_read(8'h30, s);
        bus_write(8'h40, s + 32'd3);
        bus_write(8'h60, 32'h0000_0044);
        bus_write(8'h00, 32'h0000_0001);
        ticks(2);
        read_check("R9 no flag before match", 8'h00, 32'h0000_0001);
        check("R9 irq low before match", {31'b0, alarm_irq}, 32'h0);
        ticks(32);
        read_check("R9 flag after match", 8'h00, 32'h0000_0005);
        check("R9 irq high", {31'b0, alarm_irq}, 32'h1);
        bus_write(8'h08, 32'h0000_0001);
        check("R9 irq gated by enable", {31'b0, alarm_irq}, 32'h0);
        read_check("R9 flag kept", 8'h00, 32'h0000_0004);
        bus_write(8'h00, 32'h0000_0001);
        read_check("R7 plain write keeps flag", 8'h00, 32'h0000_0005);
        check("R9 irq back", {31'b0, alarm_irq}, 32'h1);
        bus_write(8'h08, 32'h0000_0004);
        read_check("R7 clear alias drops flag", 8'h00, 32'h0000_0001);
        check("R7 irq low after clear", {31'b0, alarm_irq}, 32'h0);

        // R10 watchdog
        pulses = 0;
        bus_write(8'h50, 32'd3);
        bus_write(8'h04, 32'h0000_0010);
        ticks(8);
        check("R10 no pulse yet", pulses, 0);
        read_check("R10 two decrements in eight ticks", 8'h50, 32'd1);
        ticks(4);
        repeat (2) @(negedge clk);
        check("R10 one pulse at zero", pulses, 1);
        read_check("R10 count at zero", 8'h50, 32'd0);
        ticks(8);
        check("R10 no repeat at zero", pulses, 1);
        bus_write(8'h50, 32'd5);
        bus_write(8'h08, 32'h0000_0010);
        ticks(20);
        read_check("R10 disarmed count holds", 8'h50, 32'd5);
        check("R10 disarmed no pulse", pulses, 1);

        // R1 reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        read_check("R1 status after reset", 8'h10, 32'h9000_0000);
        read_check("R1 control after reset", 8'h00, 32'h0);
        read_check("R1 seconds after reset", 8'h30, 32'h0);
        read_check("R1 watchdog after reset", 8'h50, 32'h0);
        read_check("R1 p2 after reset", 8'h80, 32'h0);
        check("R1 irq after reset", {31'b0, alarm_irq}, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule